// File: doc/BRIEF.md
# Multichannel Dual-Clock Pull FIFO

This block moves transmit samples from a fast interface clock domain into a slower processing domain. It widens the data on the way across. Each channel takes input words of `IN_W` bits on the write clock. It delivers output words of `OUT_W` bits on the read clock, where `OUT_W/IN_W` is 1, 2, 4 or 8. Up to eight channels run in lock step. They share one pair of pointers, and each channel has its own storage.

Both sides work by request. On the write side the block raises a per-channel request strobe whenever it can take one more input word. Each word it asks for, counting requests already in flight, needs a free slot. The upstream source answers each request with a looped-back acknowledge and the data. The answer may come later than the request. On the read side the consumer raises a request strobe. One cycle later the block returns an acknowledge with a full output word, or an underflow strobe when no complete word is stored.

An underflow indication raised on the write side is carried across the clock boundary as a held level. It is reproduced as a single underflow cycle on the read side. The per-channel enables come from the read side. They are synchronized into the write clock and mirrored back to the upstream source.

Top module: `mc_pull_fifo`

## Requirements
- R1: While reset is held, `src_req`, `snk_ack` and `snk_unf` are low and `snk_data` is all zero.
- R2: Stored-but-unread input words plus outstanding `src_req` requests never exceed 2**AW (16 by default). If the source stops answering, requests stop once that credit is used up, and `src_req` then stays low.
- R3: In each output word, bits `[k*IN_W +: IN_W]` hold the k-th oldest input word of its group. The earliest word sits at k = 0.
- R4: Output words leave in arrival order, with no loss or duplication. This holds while reads and writes overlap.
- R5: A read request (any `snk_req` bit high) while a full output word is stored gives, one read clock later, `snk_ack` high for every enabled channel, new `snk_data`, and `snk_unf` low.
- R6: A read request while no full output word is stored gives, one read clock later, `snk_unf` high, `snk_ack` low and unchanged `snk_data`. A single leftover input word does not make a full word.
- R7: Each assertion of `src_unf`, even for one write clock, yields exactly one `snk_unf` cycle. Assertions that come closer together than the crossing's round trip merge into one cycle.
- R8: A channel whose `snk_en` bit is low gets no `src_req`. Its `snk_ack` stays low and its slice of `snk_data` holds its value. The other channels carry on unchanged.
- R9: `src_en` equals `snk_en` after a two-flop synchronizer into the write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side (fast) clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| src_en | output | NCH | Channel enables mirrored to the source |
| src_req | output | NCH | Per-channel request for one input word |
| src_ack | input | NCH | Looped-back acknowledge; the word is written when high |
| src_data | input | NCH*IN_W | Input words, channel c at `[c*IN_W +: IN_W]` |
| src_unf | input | 1 | Underflow indication from the source |
| rclk | input | 1 | Read-side (slow) clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| snk_en | input | NCH | Channel enables from the consumer |
| snk_req | input | NCH | Read request; any bit high reads one output word |
| snk_ack | output | NCH | Looped-back acknowledge per enabled channel |
| snk_data | output | NCH*OUT_W | Output words, channel c at `[c*OUT_W +: OUT_W]` |
| snk_unf | output | 1 | Underflow: empty read or forwarded source underflow |

## Verification
A read that drains an output word and an input word landing in storage can fall into the same stretch of cycles. The two pointers then move together near the wrap and near the credit limit. This is provoked by holding back the source until its backlog reaches the full credit. The FIFO is then drained to empty, the backlog is released, and a back-to-back read burst starts while the backlog is still being written. The outcome is judged by requiring an acknowledge on every read and an unbroken ascending word sequence across all slices of every fully written channel.

// File: rtl/pf_pkg.sv
package pf_pkg;

  localparam int MAX_CH = 8;

  // log2 of the width ratio; -1 marks an unsupported ratio
  function automatic int ratio_log2(input int ratio);
    case (ratio)
      1:       return 0;
      2:       return 1;
      4:       return 2;
      8:       return 3;
      default: return -1;
    endcase
  endfunction

endpackage

// File: rtl/pf_sync2.sv
module pf_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/pf_wr_ctrl.sv
module pf_wr_ctrl #(
  parameter int NCH = 4,
  parameter int AW  = 4,
  parameter int L2R = 1
) (
  input  logic            wclk,
  input  logic            wrst,
  input  logic [NCH-1:0]  en_w,
  input  logic [NCH-1:0]  ack,
  input  logic [AW-L2R:0] rgray_w,
  output logic [NCH-1:0]  req,
  output logic [AW:0]     wgray,
  output logic [AW-1:0]   waddr,
  output logic            wr_fire
);

  localparam int RW    = AW - L2R;
  localparam int DEPTH = 1 << AW;

  logic [AW:0]   wbin, wbin_nx, inflight, used, rbin_w;
  logic [RW:0]   rbin_r;
  logic [AW+1:0] committed;
  logic          req_q, issued, room;

  function automatic logic [RW:0] g2b(input logic [RW:0] g);
    logic [RW:0] b;
    b[RW] = g[RW];
    for (int i = RW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign rbin_r    = g2b(rgray_w);
  assign rbin_w    = (AW+1)'(rbin_r) << L2R;
  assign used      = wbin - rbin_w;
  assign req       = {NCH{req_q}} & en_w;
  assign issued    = |req;
  assign wr_fire   = |ack;
  assign committed = (AW+2)'(used) + (AW+2)'(inflight) + (AW+2)'(issued);
  assign room      = committed < (AW+2)'(DEPTH);
  assign wbin_nx   = wbin + (AW+1)'(wr_fire);
  assign waddr     = wbin[AW-1:0];

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin     <= '0;
      wgray    <= '0;
      inflight <= '0;
      req_q    <= 1'b0;
    end else begin
      req_q    <= (|en_w) && room;
      inflight <= inflight + (AW+1)'(issued) - (AW+1)'(wr_fire);
      wbin     <= wbin_nx;
      wgray    <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (wrst)
    wr_fire |-> (used < DEPTH)) else $error("write into full storage"); // R2

  AST_ACK_CREDITED: assert property (@(posedge wclk) disable iff (wrst)
    wr_fire |-> (inflight != '0 || issued)) else $error("acknowledge without request"); // R2

  AST_WGRAY_STEP: assert property (@(posedge wclk) disable iff (wrst)
    $countones(wgray ^ $past(wgray)) <= 1) else $error("write pointer jumped"); // R4

endmodule

// File: rtl/pf_rd_ctrl.sv
module pf_rd_ctrl #(
  parameter int NCH = 4,
  parameter int AW  = 4,
  parameter int L2R = 1
) (
  input  logic              rclk,
  input  logic              rrst,
  input  logic [NCH-1:0]    en,
  input  logic [NCH-1:0]    req,
  input  logic [AW:0]       wgray_r,
  input  logic              ext_unf,
  output logic [NCH-1:0]    ack_q,
  output logic              unf_q,
  output logic [AW-L2R:0]   rgray,
  output logic [AW-L2R-1:0] raddr,
  output logic              rd_fire
);

  localparam int RW = AW - L2R;

  logic [RW:0] rbin, rbin_nx;
  logic [AW:0] wbin_r;
  logic        rd_req, avail;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign wbin_r  = g2b(wgray_r);
  assign avail   = (wbin_r >> L2R) != (AW+1)'(rbin);
  assign rd_req  = |req;
  assign rd_fire = rd_req && avail;
  assign rbin_nx = rbin + (RW+1)'(rd_fire);
  assign raddr   = rbin[RW-1:0];

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin  <= '0;
      rgray <= '0;
      ack_q <= '0;
      unf_q <= 1'b0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      ack_q <= {NCH{rd_fire}} & en;
      unf_q <= (rd_req && !avail) || ext_unf;
    end
  end

  AST_ACK_AFTER_REQ: assert property (@(posedge rclk) disable iff (rrst)
    (ack_q != '0) |-> $past(rd_req)) else $error("acknowledge without read request"); // R5

  AST_RGRAY_STEP: assert property (@(posedge rclk) disable iff (rrst)
    $countones(rgray ^ $past(rgray)) <= 1) else $error("read pointer jumped"); // R4

endmodule

// File: rtl/pf_chan_store.sv
module pf_chan_store #(
  parameter int IN_W = 32,
  parameter int AW   = 4,
  parameter int L2R  = 1
) (
  input  logic                    wclk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [IN_W-1:0]         wdata,
  input  logic                    rclk,
  input  logic                    rrst,
  input  logic                    re,
  input  logic [AW-L2R-1:0]       raddr,
  output logic [(IN_W<<L2R)-1:0]  rdata
);

  localparam int R    = 1 << L2R;
  localparam int RW   = AW - L2R;
  localparam int ROWS = 1 << RW;

  // one narrow memory per slice, so every bank infers as plain block RAM
  for (genvar k = 0; k < R; k++) begin : g_slice
    logic [IN_W-1:0] mem [ROWS];
    logic [IN_W-1:0] rd_k;

    always_ff @(posedge wclk) begin
      if (we && ((waddr & AW'(R - 1)) == AW'(k)))
        mem[waddr[AW-1 -: RW]] <= wdata;
    end

    always_ff @(posedge rclk) begin
      if (rrst)    rd_k <= '0;
      else if (re) rd_k <= mem[raddr];
    end

    assign rdata[k*IN_W +: IN_W] = rd_k;
  end

endmodule

// File: rtl/pf_unf_xing.sv
module pf_unf_xing (
  input  logic wclk,
  input  logic wrst,
  input  logic unf_in,
  input  logic rclk,
  input  logic rrst,
  output logic unf_pulse
);

  logic hold, ack_w, flag_r, flag_d;

  pf_sync2 #(.W(1)) u_fwd  (.clk(rclk), .rst(rrst), .d(hold),   .q(flag_r));
  pf_sync2 #(.W(1)) u_back (.clk(wclk), .rst(wrst), .d(flag_r), .q(ack_w));

  always_ff @(posedge wclk) begin
    if (wrst) hold <= 1'b0;
    else      hold <= unf_in | (hold & ~ack_w);
  end

  always_ff @(posedge rclk) begin
    if (rrst) flag_d <= 1'b0;
    else      flag_d <= flag_r;
  end

  assign unf_pulse = flag_r & ~flag_d;

  AST_UNF_CAPTURED: assert property (@(posedge wclk) disable iff (wrst)
    unf_in |=> hold) else $error("source underflow not captured"); // R7

endmodule

// File: rtl/mc_pull_fifo.sv
module mc_pull_fifo #(
  parameter int NCH   = 4,
  parameter int IN_W  = 32,
  parameter int OUT_W = 64,
  parameter int AW    = 4
) (
  input  logic                 wclk,
  input  logic                 wrst,
  output logic [NCH-1:0]       src_en,
  output logic [NCH-1:0]       src_req,
  input  logic [NCH-1:0]       src_ack,
  input  logic [NCH*IN_W-1:0]  src_data,
  input  logic                 src_unf,
  input  logic                 rclk,
  input  logic                 rrst,
  input  logic [NCH-1:0]       snk_en,
  input  logic [NCH-1:0]       snk_req,
  output logic [NCH-1:0]       snk_ack,
  output logic [NCH*OUT_W-1:0] snk_data,
  output logic                 snk_unf
);

  // NCH must lie in 1..pf_pkg::MAX_CH, OUT_W/IN_W in {1,2,4,8}, AW > log2 ratio
  localparam int L2R = pf_pkg::ratio_log2(OUT_W / IN_W);
  localparam int RW  = AW - L2R;

  logic [NCH-1:0] en_w;
  logic [AW:0]    wgray, wgray_r;
  logic [RW:0]    rgray, rgray_w;
  logic [AW-1:0]  waddr;
  logic [RW-1:0]  raddr;
  logic           wr_fire, rd_fire, ext_unf;

  pf_sync2 #(.W(NCH))  u_en_sync   (.clk(wclk), .rst(wrst), .d(snk_en), .q(en_w));
  pf_sync2 #(.W(RW+1)) u_rptr_sync (.clk(wclk), .rst(wrst), .d(rgray),  .q(rgray_w));
  pf_sync2 #(.W(AW+1)) u_wptr_sync (.clk(rclk), .rst(rrst), .d(wgray),  .q(wgray_r));

  assign src_en = en_w;

  pf_wr_ctrl #(.NCH(NCH), .AW(AW), .L2R(L2R)) u_wr (
    .wclk(wclk), .wrst(wrst), .en_w(en_w), .ack(src_ack), .rgray_w(rgray_w),
    .req(src_req), .wgray(wgray), .waddr(waddr), .wr_fire(wr_fire)
  );

  pf_rd_ctrl #(.NCH(NCH), .AW(AW), .L2R(L2R)) u_rd (
    .rclk(rclk), .rrst(rrst), .en(snk_en), .req(snk_req), .wgray_r(wgray_r),
    .ext_unf(ext_unf), .ack_q(snk_ack), .unf_q(snk_unf), .rgray(rgray),
    .raddr(raddr), .rd_fire(rd_fire)
  );

  pf_unf_xing u_unf (
    .wclk(wclk), .wrst(wrst), .unf_in(src_unf),
    .rclk(rclk), .rrst(rrst), .unf_pulse(ext_unf)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pf_chan_store #(.IN_W(IN_W), .AW(AW), .L2R(L2R)) u_store (
      .wclk(wclk), .we(src_ack[c]), .waddr(waddr),
      .wdata(src_data[c*IN_W +: IN_W]),
      .rclk(rclk), .rrst(rrst), .re(rd_fire & snk_en[c]), .raddr(raddr),
      .rdata(snk_data[c*OUT_W +: OUT_W])
    );
  end

endmodule

// File: tb/tb_mc_pull_fifo.sv
module tb_mc_pull_fifo;

  localparam int CLK_PERIOD  = 14;  // read clock
  localparam int WCLK_PERIOD = 6;   // write clock, asynchronous to the read clock
  localparam int NCH = 4, IN_W = 32, OUT_W = 64, AW = 4;
  localparam int R = OUT_W / IN_W;
  localparam int DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0, rst = 1;
  logic [NCH-1:0]       src_en, src_req, src_ack, snk_en, snk_req, snk_ack;
  logic [NCH*IN_W-1:0]  src_data;
  logic [NCH*OUT_W-1:0] snk_data;
  logic                 src_unf, snk_unf;

  int n_chk = 0, n_fail = 0;

  always #(WCLK_PERIOD/2) wclk = ~wclk;
  always #(CLK_PERIOD/2)  rclk = ~rclk;

  mc_pull_fifo #(.NCH(NCH), .IN_W(IN_W), .OUT_W(OUT_W), .AW(AW)) dut (
    .wclk(wclk), .wrst(rst), .src_en(src_en), .src_req(src_req), .src_ack(src_ack),
    .src_data(src_data), .src_unf(src_unf), .rclk(rclk), .rrst(rst),
    .snk_en(snk_en), .snk_req(snk_req), .snk_ack(snk_ack), .snk_data(snk_data),
    .snk_unf(snk_unf)
  );

  // upstream source model: answers every request in order, can be stalled
  logic [NCH-1:0] pend_q[$];
  logic [NCH-1:0] exp_msk[$];
  int             exp_seq[$];
  int             seq = 0;
  bit             stall = 0;
  logic [NCH-1:0] m;

  always @(posedge wclk) begin
    if (rst) begin
      src_ack  <= '0;
      src_data <= '0;
    end else begin
      if (|src_req) pend_q.push_back(src_req);
      if (!stall && pend_q.size() > 0) begin
        m = pend_q.pop_front();
        src_ack <= m;
        for (int c = 0; c < NCH; c++) src_data[c*IN_W +: IN_W] <= {8'(c), 24'(seq)};
        exp_seq.push_back(seq);
        exp_msk.push_back(m);
        seq++;
      end else begin
        src_ack <= '0;
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // compare one output word against the oldest R input words and retire them
  task automatic chk_word(input logic [NCH-1:0] a, input logic [NCH*OUT_W-1:0] d);
    logic full;
    if (exp_seq.size() < R) begin
      check("R4 word read with too few words written", 64'(exp_seq.size()), 64'(R));
    end else begin
      for (int c = 0; c < NCH; c++) begin
        full = a[c];
        for (int k = 0; k < R; k++) full &= exp_msk[k][c];
        if (full)
          for (int k = 0; k < R; k++)
            check($sformatf("R3 R4 ch%0d slice%0d", c, k),
                  64'(d[c*OUT_W + k*IN_W +: IN_W]), 64'({8'(c), 24'(exp_seq[k])}));
      end
      for (int k = 0; k < R; k++) begin
        void'(exp_seq.pop_front());
        void'(exp_msk.pop_front());
      end
    end
  endtask

  task automatic rd_one(output logic [NCH-1:0] a, output logic u, output logic [NCH*OUT_W-1:0] d);
    @(negedge rclk) snk_req = '1;
    @(negedge rclk) snk_req = '0;
    a = snk_ack; u = snk_unf; d = snk_data;
  endtask

  task automatic rd_burst(input int n, input logic [NCH-1:0] hold_mask);
    logic [NCH*OUT_W-1:0] snap;
    snap = snk_data;
    @(negedge rclk) snk_req = '1;
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      if (i == n - 1) snk_req = '0;
      check("R5 ack per enabled channel", 64'(snk_ack), 64'(snk_en));
      check("R5 no underflow on stocked read", 64'(snk_unf), 64'd0);
      for (int c = 0; c < NCH; c++)
        if (hold_mask[c])
          check("R8 disabled channel data holds", snk_data[c*OUT_W +: OUT_W], snap[c*OUT_W +: OUT_W]);
      chk_word(snk_ack, snk_data);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge rclk);
    check("R1 src_req in reset", 64'(src_req), 64'd0);
    check("R1 snk_ack in reset", 64'(snk_ack), 64'd0);
    check("R1 snk_unf in reset", 64'(snk_unf), 64'd0);
    check("R1 snk_data in reset", 64'(|snk_data), 64'd0);
  endtask

  task automatic t_fill;
    repeat (40) @(negedge rclk);
    check("R2 words taken without reads", 64'(exp_seq.size()), 64'(DEPTH));
    check("R2 no request when full", 64'(src_req), 64'd0);
    check("R9 src_en mirrors snk_en", 64'(src_en), 64'(snk_en));
  endtask

  task automatic t_disable;
    snk_en = 4'b1011;
    repeat (6) @(negedge rclk);
    check("R9 src_en follows disable", 64'(src_en), 64'h0b);
    rd_burst(10, 4'b0100);
    check("R8 no request on disabled channel", 64'(src_req[2]), 64'd0);
    snk_en = '1;
    repeat (6) @(negedge rclk);
    check("R9 src_en follows re-enable", 64'(src_en), 64'h0f);
  endtask

  task automatic t_stall_empty;
    logic [NCH-1:0] a;
    logic u, seen;
    logic [NCH*OUT_W-1:0] d, snap;
    stall = 1;
    seen  = 0;
    for (int i = 0; i < 24 && !seen; i++) begin
      rd_one(a, u, d);
      if (u) seen = 1;
      else chk_word(a, d);
    end
    check("R6 empty read reached", 64'(seen), 64'd1);
    check("R6 only a partial word left", 64'(exp_seq.size() < R), 64'd1);
    snap = snk_data;
    rd_one(a, u, d);
    check("R6 underflow on empty read", 64'(u), 64'd1);
    check("R6 no ack on empty read", 64'(a), 64'd0);
    check("R6 data holds on empty read", 64'(d == snap), 64'd1);
    repeat (8) @(negedge rclk);
    check("R2 credit limit with silent source", 64'(pend_q.size() + exp_seq.size()), 64'(DEPTH));
    check("R2 requests stop at credit limit", 64'(src_req), 64'd0);
    stall = 0;
    repeat (4) @(negedge rclk);
    rd_burst(20, 4'b0000);  // R4: reads overlap the released backlog
  endtask

  task automatic t_unf(input bit twin);
    int cnt = 0;
    @(negedge wclk) src_unf = 1;
    @(negedge wclk) src_unf = twin;
    @(negedge wclk) src_unf = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge rclk);
      if (snk_unf) cnt++;
    end
    check(twin ? "R7 close pulses merge" : "R7 one underflow cycle", 64'(cnt), 64'd1);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    snk_en = '1; snk_req = '0; src_unf = 0;
    repeat (8) @(negedge rclk);
    t_reset();
    rst = 0;
    t_fill();
    rd_burst(24, 4'b0000);
    t_disable();
    t_stall_empty();
    repeat (10) @(negedge rclk);
    t_unf(0);
    t_unf(1);
    finish_run();
  end

endmodule